// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block keeps a small queue of hardware prefetch requests between a prefetch address generator and the memory-side request port of a cache. Each queued entry holds a block address and a ready time. The queue stays in insertion order, and the head is always the oldest entry. Every address that enters the block is reduced to its block address before any comparison is made.

A demand access is offered on the access stream. If the block accepts the access and does not filter it out, three steps follow in order. First, a queued entry for the same block is cancelled. Second, when serial squash is enabled, entries that are not yet due are aborted from the tail. Third, the block takes the generator's candidates one per cycle on the candidate stream and appends each one with its own ready time.

The issue port is a request/done handshake. The requester holds `issue_req` high until `issue_done` is seen. While an issue is in progress, the block probes the cache for the head entry once per cycle. It discards entries that are already cached or already outstanding, and it returns the first entry that is neither, or reports that nothing is left. `bus_req` stays high while the queue holds anything.

Back-pressure rules:
- `acc_ready` is high only while the block is idle. An access transfers on a cycle with `acc_valid && acc_ready`.
- `cand_ready` is high only during the candidate phase. A candidate transfers on a cycle with `cand_valid && cand_ready`. The candidate that carries `cand_last` closes the phase.
- An access takes priority over a pending issue request.

Top module: `pfq_manager`

## Requirements
- R1: Addresses are compared by block only: the low log2(BLK_BYTES) bits (4 bits by default) are ignored. `issue_addr` is returned with those bits cleared.
- R2: An accepted access with `acc_uncacheable` set has no effect on the queue. An access with `acc_ifetch` set has no effect when `cfg_data_only` is 1. When `cfg_data_only` is 0, an access with `acc_ifetch` set is processed like a data access.
- R3: An accepted, unfiltered access whose block equals a queued entry's block removes that entry. The remaining entries keep their order.
- R4: With `cfg_serial_squash` set, after the cancel step the block removes tail entries while the queue is non-empty and the tail's ready time is greater than or equal to `acc_time` (unsigned). It stops at the first tail entry that is earlier. With `cfg_serial_squash` clear, nothing is squashed.
- R5: Each accepted candidate that is appended gets the ready time `acc_time + cand_delay`, modulo 2^TIME_W. It goes to the tail, so entries issue in insertion order.
- R6: A candidate whose block already sits in the queue is dropped. The queue never holds two entries for the same block.
- R7: A non-duplicate candidate that arrives when the queue holds DEPTH entries evicts the head entry before it is appended. The occupancy stays at DEPTH.
- R8: During an issue, each cycle pops the head entry. If `probe_in_cache` or `probe_in_mshr` is set for it, the entry is discarded and the issue continues. Otherwise `issue_done` and `issue_found` are raised together with that entry's address. If the queue is empty, `issue_done` is raised with `issue_found` at 0.
- R9: `bus_req` is 1 exactly while the queue is non-empty. It drops once cancel, squash, eviction or issue leaves the queue empty.
- R10: `head_time` shows the head entry's ready time, or 0 when the queue is empty.
- R11: `acc_ready` is 0 from the acceptance of an unfiltered access until its candidate phase ends. `cand_ready` is 0 outside the candidate phase. Probing happens only during an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch accesses |
| cfg_serial_squash | input | 1 | Enable tail squash on each access |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle and taking accesses |
| acc_addr | input | ADDR_W | Access byte address |
| acc_time | input | TIME_W | Access time |
| acc_uncacheable | input | 1 | Access is uncacheable |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_has_cand | input | 1 | Candidates follow this access |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate phase active |
| cand_addr | input | ADDR_W | Candidate byte address |
| cand_delay | input | DELAY_W | Candidate delay |
| cand_last | input | 1 | Final candidate of this access |
| issue_req | input | 1 | Issue request, held until done |
| issue_done | output | 1 | Issue finished this cycle |
| issue_found | output | 1 | An entry is returned |
| issue_addr | output | ADDR_W | Returned block address |
| probe_valid | output | 1 | Presence probe active |
| probe_addr | output | ADDR_W | Block address probed |
| probe_in_cache | input | 1 | Probed block is cached |
| probe_in_mshr | input | 1 | Probed block is outstanding |
| bus_req | output | 1 | Queue non-empty |
| head_time | output | TIME_W | Head ready time or 0 |

## Verification
The candidate path is swept over batch sizes from zero to more than the depth. Addresses carry non-zero offsets, so block reduction, eviction at capacity and dropping of repeated blocks within one batch and across batches each show up as a different drained order. Squash is swept over access times that fall below, on and between the queued ready times, which separates `>=` from `>` and shows where the walk from the tail stops. Cancel and the three filter cases use an access aimed at a queued block, so that a filtered access and a processed one give different drains. Issue is run with hits in the cache, hits in the outstanding set, and all entries hitting, which separates skip, return and the empty result. A delay that wraps the time field checks that the addition is modular.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CANCEL,
    ST_SQUASH,
    ST_CAND,
    ST_ISSUE
  } pfq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_REMOVE,
    OP_POP_TAIL,
    OP_PUSH
  } pfq_op_e;

endpackage

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BLK_W  = 12,
  parameter int TIME_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pfq_op_e                       op,
  input  logic [IDX_W-1:0]              op_idx,
  input  logic [BLK_W-1:0]              in_blk,
  input  logic [TIME_W-1:0]             in_time,
  output logic [DEPTH-1:0][BLK_W-1:0]   e_blk,
  output logic [DEPTH-1:0][TIME_W-1:0]  e_time,
  output logic [CNT_W-1:0]              count
);

  logic [DEPTH-1:0][BLK_W-1:0]  n_blk;
  logic [DEPTH-1:0][TIME_W-1:0] n_time;
  logic [CNT_W-1:0]             n_cnt;

  // slot 0 is the head; live entries occupy slots below count
  always_comb begin
    n_blk  = e_blk;
    n_time = e_time;
    n_cnt  = count;
    case (op)
      OP_REMOVE: begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (i >= int'(op_idx)) begin
            n_blk[i]  = e_blk[i+1];
            n_time[i] = e_time[i+1];
          end
        end
        n_cnt = count - 1'b1;
      end
      OP_POP_TAIL: n_cnt = count - 1'b1;
      OP_PUSH: begin
        if (count == CNT_W'(DEPTH)) begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            n_blk[i]  = e_blk[i+1];
            n_time[i] = e_time[i+1];
          end
          n_blk[DEPTH-1]  = in_blk;
          n_time[DEPTH-1] = in_time;
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == count) begin
              n_blk[i]  = in_blk;
              n_time[i] = in_time;
            end
          end
          n_cnt = count + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_blk  <= '0;
      e_time <= '0;
      count  <= '0;
    end else begin
      e_blk  <= n_blk;
      e_time <= n_time;
      count  <= n_cnt;
    end
  end

endmodule

// File: rtl/pfq_match.sv
module pfq_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] e_blk,
  input  logic [CNT_W-1:0]            count,
  input  logic [BLK_W-1:0]            key,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);

  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = (CNT_W'(g) < count) && (e_blk[g] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pfq_manager.sv
module pfq_manager
  import pfq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16,
  parameter int DEPTH     = 4,
  parameter int TIME_W    = 16,
  parameter int DELAY_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_data_only,
  input  logic               cfg_serial_squash,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [TIME_W-1:0]  acc_time,
  input  logic               acc_uncacheable,
  input  logic               acc_ifetch,
  input  logic               acc_has_cand,
  input  logic               cand_valid,
  output logic               cand_ready,
  input  logic [ADDR_W-1:0]  cand_addr,
  input  logic [DELAY_W-1:0] cand_delay,
  input  logic               cand_last,
  input  logic               issue_req,
  output logic               issue_done,
  output logic               issue_found,
  output logic [ADDR_W-1:0]  issue_addr,
  output logic               probe_valid,
  output logic [ADDR_W-1:0]  probe_addr,
  input  logic               probe_in_cache,
  input  logic               probe_in_mshr,
  output logic               bus_req,
  output logic [TIME_W-1:0]  head_time
);

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  pfq_state_e                  state, st_n;
  pfq_op_e                     op;
  logic [IDX_W-1:0]            op_idx;
  logic [BLK_W-1:0]            in_blk;
  logic [TIME_W-1:0]           in_time;
  logic [DEPTH-1:0][BLK_W-1:0]  e_blk;
  logic [DEPTH-1:0][TIME_W-1:0] e_time;
  logic [CNT_W-1:0]            q_count;
  logic                        q_empty;
  logic [BLK_W-1:0]            key;
  logic                        m_hit;
  logic [IDX_W-1:0]            m_idx;
  logic [BLK_W-1:0]            acc_blk_q;
  logic [TIME_W-1:0]           acc_t_q;
  logic                        has_cand_q;
  logic [TIME_W-1:0]           tail_time;
  logic                        acc_ignore;
  logic [BLK_W-1:0]            cand_blk;
  pfq_state_e                  after_cut;

  assign cand_blk   = cand_addr[ADDR_W-1:OFF_W];
  assign acc_ignore = acc_uncacheable | (acc_ifetch & cfg_data_only);
  assign q_empty    = (q_count == '0);
  assign key        = (state == ST_CAND) ? cand_blk : acc_blk_q;
  assign after_cut  = has_cand_q ? ST_CAND : ST_IDLE;
  assign in_blk     = cand_blk;
  assign in_time    = acc_t_q + TIME_W'(cand_delay);

  assign issue_addr = {e_blk[0], {OFF_W{1'b0}}};
  assign probe_addr = issue_addr;
  assign bus_req    = !q_empty;
  assign head_time  = q_empty ? '0 : e_time[0];

  pfq_store #(.DEPTH(DEPTH), .BLK_W(BLK_W), .TIME_W(TIME_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .op_idx  (op_idx),
    .in_blk  (in_blk),
    .in_time (in_time),
    .e_blk   (e_blk),
    .e_time  (e_time),
    .count   (q_count)
  );

  pfq_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .e_blk (e_blk),
    .count (q_count),
    .key   (key),
    .hit   (m_hit),
    .idx   (m_idx)
  );

  always_comb begin
    tail_time = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i + 1) == q_count) tail_time = e_time[i];
    end
  end

  always_comb begin
    st_n        = state;
    op          = OP_NONE;
    op_idx      = m_idx;
    acc_ready   = 1'b0;
    cand_ready  = 1'b0;
    probe_valid = 1'b0;
    issue_done  = 1'b0;
    issue_found = 1'b0;
    case (state)
      ST_IDLE: begin
        acc_ready = 1'b1;
        if (acc_valid) begin
          if (!acc_ignore) st_n = ST_CANCEL;
        end else if (issue_req) begin
          st_n = ST_ISSUE;
        end
      end
      ST_CANCEL: begin
        if (m_hit) op = OP_REMOVE;
        st_n = cfg_serial_squash ? ST_SQUASH : after_cut;
      end
      ST_SQUASH: begin
        if (!q_empty && (tail_time >= acc_t_q)) op = OP_POP_TAIL;
        else st_n = after_cut;
      end
      ST_CAND: begin
        cand_ready = 1'b1;
        if (cand_valid) begin
          if (!m_hit) op = OP_PUSH;
          if (cand_last) st_n = ST_IDLE;
        end
      end
      ST_ISSUE: begin
        if (q_empty) begin
          issue_done = 1'b1;
          st_n       = ST_IDLE;
        end else begin
          probe_valid = 1'b1;
          op          = OP_REMOVE;
          op_idx      = '0;
          if (!(probe_in_cache || probe_in_mshr)) begin
            issue_done  = 1'b1;
            issue_found = 1'b1;
            st_n        = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      acc_blk_q  <= '0;
      acc_t_q    <= '0;
      has_cand_q <= 1'b0;
    end else begin
      state <= st_n;
      if (state == ST_IDLE && acc_valid) begin
        acc_blk_q  <= acc_addr[ADDR_W-1:OFF_W];
        acc_t_q    <= acc_time;
        has_cand_q <= acc_has_cand;
      end
    end
  end

endmodule

// File: rtl/pfq_manager_chk.sv
module pfq_manager_chk #(
  parameter int ADDR_W = 16,
  parameter int TIME_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_data_only,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_uncacheable,
  input logic              acc_ifetch,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic              issue_done,
  input logic              issue_found,
  input logic              probe_valid,
  input logic              probe_in_cache,
  input logic              probe_in_mshr,
  input logic              bus_req,
  input logic [TIME_W-1:0] head_time,
  input logic [CNT_W-1:0]  q_count
);

  // R2
  filtered_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && (acc_uncacheable || (acc_ifetch && cfg_data_only))
    |=> $stable(q_count) && acc_ready);

  // R7
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready && (q_count == CNT_W'(DEPTH)) |=> q_count == CNT_W'(DEPTH));

  // R8
  found_not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_done && issue_found |-> probe_valid && !probe_in_cache && !probe_in_mshr);

  // R9
  empty_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_done && !issue_found |=> !bus_req);

  // R10
  idle_head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> head_time == '0);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && !acc_uncacheable && !(acc_ifetch && cfg_data_only)
    |=> !acc_ready);

  // R11
  phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ready && (cand_ready || probe_valid)));

endmodule

bind pfq_manager pfq_manager_chk #(.ADDR_W(ADDR_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_data_only   (cfg_data_only),
  .acc_valid       (acc_valid),
  .acc_ready       (acc_ready),
  .acc_uncacheable (acc_uncacheable),
  .acc_ifetch      (acc_ifetch),
  .cand_valid      (cand_valid),
  .cand_ready      (cand_ready),
  .issue_done      (issue_done),
  .issue_found     (issue_found),
  .probe_valid     (probe_valid),
  .probe_in_cache  (probe_in_cache),
  .probe_in_mshr   (probe_in_mshr),
  .bus_req         (bus_req),
  .head_time       (head_time),
  .q_count         (q_count)
);

// File: tb/test_pfq_manager.sv
`timescale 1ns/1ps
module test_pfq_manager;
  localparam int ADDR_W = 16, TIME_W = 16, DELAY_W = 8, DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_donly, cfg_squash;
  logic acc_valid, acc_ready, acc_unc, acc_ifc, acc_has;
  logic [15:0] acc_addr, acc_time;
  logic cand_valid, cand_ready, cand_last;
  logic [15:0] cand_addr;
  logic [7:0] cand_delay;
  logic issue_req, issue_done, issue_found, probe_valid, probe_in_cache, probe_in_mshr, bus_req;
  logic [15:0] issue_addr, probe_addr, head_time;

  pfq_manager #(.ADDR_W(ADDR_W), .BLK_BYTES(16), .DEPTH(DEPTH), .TIME_W(TIME_W), .DELAY_W(DELAY_W))
  i_pfq_manager (
    .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_donly), .cfg_serial_squash(cfg_squash),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_time(acc_time),
    .acc_uncacheable(acc_unc), .acc_ifetch(acc_ifc), .acc_has_cand(acc_has),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
    .cand_delay(cand_delay), .cand_last(cand_last),
    .issue_req(issue_req), .issue_done(issue_done), .issue_found(issue_found), .issue_addr(issue_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_in_cache(probe_in_cache),
    .probe_in_mshr(probe_in_mshr), .bus_req(bus_req), .head_time(head_time)
  );

  int checks = 0, errors = 0;

  // cache environment: one cached block and one outstanding block
  logic c_en, h_en;
  logic [11:0] c_blk, h_blk;
  assign probe_in_cache = probe_valid && c_en && (probe_addr[15:4] == c_blk);
  assign probe_in_mshr  = probe_valid && h_en && (probe_addr[15:4] == h_blk);

  // reference queue
  logic [11:0] m_blk [DEPTH];
  logic [15:0] m_tim [DEPTH];
  int m_cnt = 0;
  logic [15:0] cand_a [8];
  logic [7:0]  cand_d [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_del(input int i);
    for (int j = i; j < m_cnt - 1; j++) begin
      m_blk[j] = m_blk[j+1];
      m_tim[j] = m_tim[j+1];
    end
    m_cnt--;
  endtask

  function automatic bit env_hit(input logic [11:0] b);
    return (c_en && b == c_blk) || (h_en && b == h_blk);
  endfunction

  task automatic m_notify(input logic [15:0] a, input logic [15:0] t, input bit unc, input bit ifc, input int n);
    bit dup;
    logic [11:0] b;
    if (unc || (ifc && cfg_donly)) return;
    for (int i = 0; i < m_cnt; i++) if (m_blk[i] == a[15:4]) begin m_del(i); break; end
    if (cfg_squash) while (m_cnt > 0 && m_tim[m_cnt-1] >= t) m_cnt--;
    for (int k = 0; k < n; k++) begin
      b = cand_a[k][15:4];
      dup = 0;
      for (int i = 0; i < m_cnt; i++) if (m_blk[i] == b) dup = 1;
      if (!dup) begin
        if (m_cnt == DEPTH) m_del(0);
        m_blk[m_cnt] = b;
        m_tim[m_cnt] = t + {8'h00, cand_d[k]};
        m_cnt++;
      end
    end
  endtask

  // called at a negedge; returns at a negedge with the block idle
  task automatic notify(input logic [15:0] a, input logic [15:0] t, input bit unc, input bit ifc, input int n);
    m_notify(a, t, unc, ifc, n);
    acc_valid = 1; acc_addr = a; acc_time = t; acc_unc = unc; acc_ifc = ifc; acc_has = (n > 0);
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
    acc_valid = 0;
    if (!(unc || (ifc && cfg_donly))) begin
      chk("R11 acc_ready low while busy", acc_ready, 0);
      for (int k = 0; k < n; k++) begin
        cand_valid = 1; cand_addr = cand_a[k]; cand_delay = cand_d[k]; cand_last = (k == n - 1);
        while (!cand_ready) @(negedge clk);
        @(negedge clk);
      end
      cand_valid = 0; cand_last = 0;
      while (!acc_ready) @(negedge clk);
      chk("R11 cand_ready low when idle", cand_ready, 0);
    end
  endtask

  task automatic issue(output logic found, output logic [15:0] addr);
    issue_req = 1;
    @(negedge clk);
    while (!issue_done) @(negedge clk);
    found = issue_found;
    addr = issue_addr;
    issue_req = 0;
    @(negedge clk);
  endtask

  // drain the queue through the issue port, comparing with the reference
  task automatic drain(input string req);
    logic f;
    logic [15:0] a;
    for (int it = 0; it < 10; it++) begin
      chk({req, " R10 head_time"}, head_time, (m_cnt > 0) ? m_tim[0] : 16'h0);
      chk({req, " R9 bus_req"}, bus_req, m_cnt > 0);
      while (m_cnt > 0 && env_hit(m_blk[0])) m_del(0);
      issue(f, a);
      if (m_cnt == 0) begin
        chk({req, " R8 found"}, f, 0);
        chk({req, " R9 bus_req after empty"}, bus_req, 0);
        break;
      end
      chk({req, " R8 found"}, f, 1);
      chk({req, " R1 addr"}, a, {m_blk[0], 4'h0});
      m_del(0);
    end
  endtask

  task automatic fill3;
    cand_a[0] = 16'h0105; cand_d[0] = 8'd10;
    cand_a[1] = 16'h020A; cand_d[1] = 8'd20;
    cand_a[2] = 16'h030F; cand_d[2] = 8'd30;
    notify(16'hF000, 16'd100, 0, 0, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic f;
    logic [15:0] a;
    rst_n = 0; cfg_donly = 0; cfg_squash = 0;
    acc_valid = 0; acc_addr = 0; acc_time = 0; acc_unc = 0; acc_ifc = 0; acc_has = 0;
    cand_valid = 0; cand_addr = 0; cand_delay = 0; cand_last = 0; issue_req = 0;
    c_en = 0; h_en = 0; c_blk = 0; h_blk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R9 reset bus_req", bus_req, 0);
    chk("R10 reset head_time", head_time, 0);
    chk("R11 reset acc_ready", acc_ready, 1);
    chk("R11 reset cand_ready", cand_ready, 0);
    issue(f, a);
    chk("R8 empty issue", f, 0);

    // R5 R6 R7 R1: candidate batch sweep 0..6 with offsets
    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k < n; k++) begin
        cand_a[k] = 16'h1000 + 16'(k * 16'h10) + 16'(k);
        cand_d[k] = 8'(k * 3 + 1);
      end
      notify(16'h8000, 16'(n * 100), 0, 0, n);
      drain("R5 R7 sweep");
    end

    // R6: duplicates within a batch and against the queue
    cand_a[0] = 16'h0123; cand_d[0] = 8'd5;
    cand_a[1] = 16'h012F; cand_d[1] = 8'd9;
    cand_a[2] = 16'h0450; cand_d[2] = 8'd7;
    notify(16'h8000, 16'd50, 0, 0, 3);
    cand_a[0] = 16'h0451; cand_d[0] = 8'd1;
    cand_a[1] = 16'h0600; cand_d[1] = 8'd2;
    notify(16'h8000, 16'd60, 0, 0, 2);
    drain("R6 dup");

    // R5: time wrap
    cand_a[0] = 16'h0700; cand_d[0] = 8'h20;
    notify(16'h8000, 16'hFFF0, 0, 0, 1);
    chk("R5 wrap head_time", head_time, 16'h0010);
    drain("R5 wrap");

    // R3: cancel middle entry by offset-differing address
    fill3();
    notify(16'h0209, 16'd200, 0, 0, 0);
    drain("R3 cancel");

    // R2: filtered accesses leave queue intact; ifetch processed when not data-only
    fill3();
    notify(16'h0100, 16'd200, 1, 0, 0);
    cfg_donly = 1;
    notify(16'h0200, 16'd200, 0, 1, 0);
    cfg_donly = 0;
    notify(16'h0300, 16'd200, 0, 1, 0);
    drain("R2 filter");

    // R4: squash sweep across and on ready times
    for (int t = 5; t <= 45; t += 5) begin
      cfg_squash = 0;
      for (int k = 0; k < 4; k++) begin
        cand_a[k] = 16'(16'h0100 * (k + 1));
        cand_d[k] = 8'(10 * (k + 1));
      end
      notify(16'hF000, 16'd0, 0, 0, 4);
      cfg_squash = 1;
      notify(16'hE000, 16'(t), 0, 0, 0);
      drain("R4 squash");
    end
    // squash disabled keeps everything
    cfg_squash = 0;
    fill3();
    notify(16'hE000, 16'd0, 0, 0, 0);
    drain("R4 no squash");
    // squash with candidates following
    cfg_squash = 1;
    fill3();
    cand_a[0] = 16'h0900; cand_d[0] = 8'd3;
    notify(16'hE000, 16'd115, 0, 0, 1);
    drain("R4 squash then insert");
    cfg_squash = 0;

    // R8: skip cache hit and mshr hit
    fill3();
    c_en = 1; c_blk = 12'h010; h_en = 1; h_blk = 12'h020;
    drain("R8 skip");
    // all entries hit
    cand_a[0] = 16'h0100; cand_d[0] = 8'd1;
    cand_a[1] = 16'h0200; cand_d[1] = 8'd2;
    notify(16'hF000, 16'd10, 0, 0, 2);
    drain("R8 all hit");
    c_en = 0; h_en = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule